// File: doc/BRIEF.md
# Byte-Count SPI Master Engine

This block is a serial peripheral interface master that moves a programmed number of bytes per transfer. A configuration word chooses the serial clock rate, clock polarity and phase, bit order within each byte, and whether the transmit and receive paths are in use. Enabling both gives a full-duplex exchange. Enabling only one gives a write-only or read-only transfer. A start pulse with a 16-bit byte count launches a transfer. The engine then shifts exactly that many bytes and returns to idle. Chip select is driven by surrounding logic.

Bytes to send come in through a one-entry valid/ready hand-off. Received bytes are held in a one-entry buffer with a valid flag. While transmit is enabled and the next byte has not yet arrived, the engine waits between bytes with the serial clock parked at its idle level. A completion flag drives an interrupt output when the interrupt is enabled. A three-bit write-one-to-clear input flushes the pending transmit byte, the received byte, or the completion flag.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, busy, irq and rx_valid are low, tx_ready is high and sck is low. The configuration word resets to 0x380, which gives MSB-first order, transmit and receive enabled, mode 0, rate 0 and interrupt disabled.
- R2: The configuration word bits [3:0] hold the rate code r. Within a byte, consecutive sck edges are 2^r system clocks apart, so one sck period is 2^(r+1) clocks. Codes above 11 act as 11.
- R3: Configuration bit 5 is polarity and sets the idle level of sck. Each byte takes exactly 16 sck edges, and sck is at its idle level whenever busy is low.
- R4: Configuration bit 4 is phase. When it is 0, miso is sampled on the first edge of each bit and mosi changes on the second. When it is 1, mosi changes on the first edge and miso is sampled on the second. The data a slave captures matches the transmitted byte in all four modes.
- R5: Configuration bit 9 set sends and receives the most significant bit first. Clear sends and receives the least significant bit first.
- R6: With receive enabled (bit 8), each completed byte appears on rx_data with rx_valid high, holding the bits sampled from miso.
- R7: With transmit disabled (bit 7 clear), mosi carries 0xFF filler and the engine never waits for transmit data.
- R8: With receive disabled, incoming bits are discarded and rx_valid never rises.
- R9: busy rises the cycle after an accepted start and falls after the final sck edge of exactly start_count bytes.
- R10: With transmit enabled, the engine holds sck at idle and stays busy while no transmit byte is pending.
- R11: A start while busy is ignored. A start with a count of zero is ignored.
- R12: clr bit 0 drops a pending transmit byte (tx_ready returns high). Bit 1 clears rx_valid. Bit 2 clears the completion flag.
- R13: The completion flag is set when the last byte finishes. irq is the flag gated by configuration bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Configuration write strobe, taken only while idle |
| ctrl_wdata | input | 10 | Configuration word: [9] msb first, [8] rx enable, [7] tx enable, [6] irq enable, [5] polarity, [4] phase, [3:0] rate |
| start | input | 1 | Start pulse |
| start_count | input | 16 | Number of bytes for the transfer |
| clr | input | 3 | Write-one-to-clear: [0] tx byte, [1] rx byte, [2] completion flag |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit holding slot is empty |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach is the wait between bytes. There, the engine is busy with transmit enabled but has no data, and sck must stay parked. The stimulus reaches it by starting a transfer without offering a transmit byte, then holding back for dozens of cycles before feeding it. A second hard case is a start that arrives mid-transfer. A start carrying a larger count is injected while the engine is shifting, and the total number of sck edges seen by a behavioural slave must still match the original count.

// File: rtl/spim_pkg.sv
// Shared widths, configuration layout and state encoding for the SPI master.
// Assumes 8-bit bytes and a 4-bit rate code.
package spim_pkg;
    localparam int BYTE_W = 8;
    localparam int RATE_W = 4;
    localparam int CTRL_W = 6 + RATE_W;
    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES);

    typedef struct packed {
        logic              msb_first;
        logic              rx_en;
        logic              tx_en;
        logic              irq_en;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = ctrl_t'(10'h380);

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} state_t;
endpackage

// File: rtl/spim_divider.sv
// Half-period timer: while run is high, pulses tick once every 2^rate clocks.
// Assumes rate codes above MAX_RATE are clamped; the counter restarts when run drops.
module spim_divider #(
    parameter int MAX_RATE = 11,
    parameter int RATE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = MAX_RATE;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  term;
    logic [RATE_W-1:0] eff_rate;

    // Clamp the rate code and derive the terminal count.
    always_comb begin
        eff_rate = (rate > RATE_W'(MAX_RATE)) ? RATE_W'(MAX_RATE) : rate;
        term     = ({{(CNT_W-1){1'b0}}, 1'b1} << eff_rate) - 1'b1;
        tick     = run && (cnt_q == term);
    end

    // Count clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spim_shifter.sv
// Transmit and receive shift registers with selectable bit order.
// Assumes load, shift and sample are single-cycle strobes from the sequencer.
module spim_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  logic         shift,
    input  logic         sample,
    input  logic         msb_first,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_next
);
    logic [W-1:0] tsh_q;
    logic [W-1:0] rsh_q;
    logic [W-1:0] rx_shifted;

    // Present the outgoing bit and form the receive value including this cycle's sample.
    always_comb begin
        mosi       = msb_first ? tsh_q[W-1] : tsh_q[0];
        rx_shifted = msb_first ? {rsh_q[W-2:0], miso} : {miso, rsh_q[W-1:1]};
        rx_next    = sample ? rx_shifted : rsh_q;
    end

    // Transmit shifter: load a byte, then move one bit per shift strobe, filling with ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tsh_q <= '1;
        else if (load)
            tsh_q <= load_byte;
        else if (shift)
            tsh_q <= msb_first ? {tsh_q[W-2:0], 1'b1} : {1'b1, tsh_q[W-1:1]};
    end

    // Receive shifter: take one miso bit per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsh_q <= '0;
        else
            rsh_q <= rx_next;
    end
endmodule

// File: rtl/spi_byte_master.sv
// SPI master that shifts a programmed count of bytes per start pulse.
// Assumes chip select is handled outside; configuration writes land only while idle.
module spi_byte_master
    import spim_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MAX_RATE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [2:0]        clr,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              busy,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    ctrl_t             ctrl_q;
    state_t            state_q;
    logic [CNT_W-1:0]  remain_q;
    logic [EDGE_W-1:0] edge_q;
    logic              phase_q;
    logic              tx_full_q;
    logic [BYTE_W-1:0] tx_buf_q;
    logic              rx_full_q;
    logic [BYTE_W-1:0] rx_buf_q;
    logic              irq_q;

    logic              tick;
    logic              load;
    logic              sample;
    logic              shift;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_next;

    spim_divider #(.MAX_RATE(MAX_RATE), .RATE_W(RATE_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_RUN),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    spim_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_byte(ctrl_q.tx_en ? tx_buf_q : '1),
        .shift    (shift),
        .sample   (sample),
        .msb_first(ctrl_q.msb_first),
        .miso     (miso),
        .mosi     (mosi),
        .rx_next  (rx_next)
    );

    // Decode edge roles from the edge index and the phase setting.
    always_comb begin
        load      = (state_q == ST_LOAD) && (!ctrl_q.tx_en || tx_full_q);
        sample    = tick && (edge_q[0] == ctrl_q.cpha);
        shift     = tick && (edge_q[0] != ctrl_q.cpha) && (edge_q != '0) && (edge_q != LAST_EDGE);
        byte_done = tick && (edge_q == LAST_EDGE);
        busy      = (state_q != ST_IDLE);
        sck       = ctrl_q.cpol ^ phase_q;
        irq       = irq_q && ctrl_q.irq_en;
        tx_ready  = !tx_full_q;
        rx_valid  = rx_full_q;
        rx_data   = rx_buf_q;
    end

    // Configuration register, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (ctrl_we && state_q == ST_IDLE)
            ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    // Transmit holding slot: filled by the hand-off, emptied by a byte load or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full_q <= 1'b0;
            tx_buf_q  <= '0;
        end else if (clr[0] || (load && ctrl_q.tx_en)) begin
            tx_full_q <= 1'b0;
        end else if (tx_valid && !tx_full_q) begin
            tx_full_q <= 1'b1;
            tx_buf_q  <= tx_data;
        end
    end

    // Receive holding slot: captured at the end of each byte when receive is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full_q <= 1'b0;
            rx_buf_q  <= '0;
        end else if (byte_done && ctrl_q.rx_en) begin
            rx_full_q <= 1'b1;
            rx_buf_q  <= rx_next;
        end else if (clr[1]) begin
            rx_full_q <= 1'b0;
        end
    end

    // Transfer sequencer: byte count, edge index, sck phase and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            edge_q   <= '0;
            phase_q  <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (clr[2])
                irq_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start && start_count != '0) begin
                        remain_q <= start_count;
                        state_q  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (load) begin
                        edge_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        phase_q <= ~phase_q;
                        edge_q  <= edge_q + 1'b1;
                        if (byte_done) begin
                            remain_q <= remain_q - 1'b1;
                            if (remain_q == CNT_W'(1)) begin
                                state_q <= ST_IDLE;
                                irq_q   <= 1'b1;
                            end else begin
                                state_q <= ST_LOAD;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spim_checker.sv
// Temporal checks for the SPI master, attached to the top through bind.
// Assumes the bound signals are the top's ports and sequencer state.
module spim_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       irq,
    input logic       sck,
    input logic       start,
    input logic       rx_valid,
    input logic [2:0] clr,
    input logic       cpol,
    input logic       irq_en,
    input logic       rx_en,
    input logic       load_wait
);
    a_r3_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);

    a_r10_stall_parks_sck: assert property (@(posedge clk) disable iff (!rst_n)
        load_wait |-> (sck == cpol && busy));

    a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r13_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

    a_r12_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[2] && !busy) |=> !irq);

    a_r8_rx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> rx_en);
endmodule

bind spi_byte_master spim_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .irq      (irq),
    .sck      (sck),
    .start    (start),
    .rx_valid (rx_valid),
    .clr      (clr),
    .cpol     (ctrl_q.cpol),
    .irq_en   (ctrl_q.irq_en),
    .rx_en    (ctrl_q.rx_en),
    .load_wait(state_q == spim_pkg::ST_LOAD && ctrl_q.tx_en && !tx_full_q)
);

// File: tb/spi_byte_master_bench.sv
// Directed bench: a behavioural slave watches sck, and each scenario task checks its own results.
module spi_byte_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [9:0] ctrl_wdata = '0;
    logic       start = 1'b0;
    logic [15:0] start_count = '0;
    logic [2:0] clr = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready, rx_valid, busy, irq, sck, mosi, miso;
    logic [7:0] rx_data;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_byte_master u_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .start(start), .start_count(start_count), .clr(clr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    // Behavioural slave
    logic       sl_arm = 1'b0;
    logic       sck_prev = 1'b0;
    logic       b_msb = 1'b1;
    logic       b_cpha = 1'b0;
    int         sl_edges = 0;
    int         sl_byte = 0;
    int         sl_i = 0;
    int         sl_t0 = 0;
    int         sl_t1 = 0;
    logic [7:0] sl_sh = '0;
    logic [7:0] sl_cap = '0;
    logic [7:0] sl_out [8];
    logic [7:0] sl_got [8];
    logic [7:0] rx_got [8];

    assign miso = b_msb ? sl_sh[7] : sl_sh[0];

    always @(negedge clk) begin
        if (sl_arm && sck !== sck_prev) begin
            sl_i = sl_edges % 16;
            if (sl_edges == 0) sl_t0 = cyc;
            if (sl_edges == 1) sl_t1 = cyc;
            if (sl_i[0] == b_cpha)
                sl_cap = b_msb ? {sl_cap[6:0], mosi} : {mosi, sl_cap[7:1]};
            else if (sl_i != 0 && sl_i != 15)
                sl_sh = b_msb ? {sl_sh[6:0], 1'b0} : {1'b0, sl_sh[7:1]};
            if (sl_i == 15) begin
                sl_got[sl_byte % 8] = sl_cap;
                sl_byte++;
                sl_sh = sl_out[sl_byte % 8];
            end
            sl_edges++;
        end
        sck_prev = sck;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    function automatic logic [7:0] mtx(int s, int k);
        return 8'(s * 37 + k * 91 + 8'h5A);
    endfunction

    function automatic logic [7:0] slb(int s, int k);
        return 8'(s * 53 + k * 29 + 8'hC3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [9:0] w);
        @(negedge clk) ctrl_we = 1'b1; ctrl_wdata = w;
        @(negedge clk) ctrl_we = 1'b0;
    endtask

    task automatic pulse_clr(input logic [2:0] c);
        @(negedge clk) clr = c;
        @(negedge clk) clr = '0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 60000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk) start = 1'b1; start_count = 16'(n);
        @(negedge clk) start = 1'b0;
    endtask

    // One transfer against the slave model, with full result checks.
    task automatic run_xfer(input logic [9:0] w, input bit do_wr, input int n,
                            input int seed, input bit poke, input string dtag);
        if (do_wr) wr_ctrl(w);
        b_msb = w[9]; b_cpha = w[4];
        repeat (2) @(negedge clk);
        chk(sck === w[5], "R3 idle level", sck, w[5]);
        for (int k = 0; k < 8; k++) begin
            sl_out[k] = slb(seed, k);
            sl_got[k] = '0;
            rx_got[k] = '0;
        end
        sl_edges = 0; sl_byte = 0; sl_sh = sl_out[0]; sl_cap = '0; sl_arm = 1'b1;
        pulse_start(n);
        chk(busy === 1'b1, "R9 busy after start", busy, 1);
        fork
            begin
                if (w[7]) begin
                    for (int k = 0; k < n; k++) begin
                        while (!tx_ready) @(negedge clk);
                        tx_valid = 1'b1; tx_data = mtx(seed, k);
                        @(negedge clk) tx_valid = 1'b0;
                    end
                end
            end
            begin
                if (w[8]) begin
                    for (int k = 0; k < n; k++) begin
                        int t = 0;
                        while (!rx_valid && t < 60000) begin
                            @(negedge clk);
                            t++;
                        end
                        rx_got[k] = rx_data;
                        clr = 3'b010;
                        @(negedge clk) clr = '0;
                    end
                end
            end
            begin
                if (poke) begin
                    repeat (10) @(negedge clk);
                    start = 1'b1; start_count = 16'd5;
                    @(negedge clk) start = 1'b0;
                end
                wait_idle();
            end
        join
        repeat (2) @(negedge clk);
        sl_arm = 1'b0;
        chk(sl_edges == 16 * n, poke ? "R11 start while busy" : "R9 edge count", sl_edges, 16 * n);
        chk(busy === 1'b0, "R9 busy low at end", busy, 0);
        chk(sck === w[5], "R3 sck back to idle", sck, w[5]);
        chk(sl_t1 - sl_t0 == (1 << w[3:0]), "R2 half period", sl_t1 - sl_t0, 1 << w[3:0]);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = w[7] ? mtx(seed, k) : 8'hFF;
            chk(sl_got[k] === e, w[7] ? dtag : "R7 filler", sl_got[k], e);
            if (w[8]) chk(rx_got[k] === slb(seed, k), "R6 rx byte", rx_got[k], slb(seed, k));
        end
        if (!w[8]) chk(rx_valid === 1'b0, "R8 rx discarded", rx_valid, 0);
    endtask

    task automatic t_reset();
        chk(busy === 1'b0 && irq === 1'b0 && rx_valid === 1'b0, "R1 flags low",
            {busy, irq, rx_valid}, 0);
        chk(tx_ready === 1'b1 && sck === 1'b0, "R1 tx_ready high, sck low", {tx_ready, sck}, 2'b10);
        run_xfer(10'h380, 1'b0, 2, 1, 1'b0, "R1 default MSB duplex");
    endtask

    task automatic t_modes();
        run_xfer(10'h380, 1'b1, 3, 2, 1'b0, "R4 mode0");
        run_xfer(10'h192, 1'b1, 2, 3, 1'b0, "R5 lsb mode1");
        run_xfer(10'h3A1, 1'b1, 2, 4, 1'b0, "R4 mode2");
        run_xfer(10'h1B3, 1'b1, 2, 5, 1'b0, "R5 lsb mode3");
    endtask

    task automatic t_paths();
        run_xfer(10'h300, 1'b1, 2, 6, 1'b0, "R7");
        run_xfer(10'h280, 1'b1, 2, 7, 1'b0, "R8 tx only");
    endtask

    task automatic t_stall();
        wr_ctrl(10'h380);
        b_msb = 1'b1; b_cpha = 1'b0;
        sl_edges = 0; sl_byte = 0; sl_out[0] = 8'h3C; sl_sh = 8'h3C; sl_arm = 1'b1;
        pulse_start(1);
        repeat (40) @(negedge clk);
        chk(busy === 1'b1, "R10 busy while waiting", busy, 1);
        chk(sl_edges == 0 && sck === 1'b0, "R10 sck parked", sl_edges, 0);
        tx_valid = 1'b1; tx_data = 8'h96;
        @(negedge clk) tx_valid = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        sl_arm = 1'b0;
        chk(sl_got[0] === 8'h96, "R10 byte after stall", sl_got[0], 8'h96);
        pulse_clr(3'b010);
    endtask

    task automatic t_start_rules();
        run_xfer(10'h381, 1'b1, 2, 8, 1'b1, "R4 poke data");
        pulse_start(0);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R11 zero count ignored", busy, 0);
    endtask

    task automatic t_clear();
        wr_ctrl(10'h300);
        @(negedge clk) tx_valid = 1'b1; tx_data = 8'h11;
        @(negedge clk) tx_valid = 1'b0;
        chk(tx_ready === 1'b0, "R12 tx slot full", tx_ready, 0);
        pulse_clr(3'b001);
        chk(tx_ready === 1'b1, "R12 tx slot cleared", tx_ready, 1);
        pulse_start(1);
        wait_idle();
        @(negedge clk);
        chk(rx_valid === 1'b1, "R12 rx valid before clear", rx_valid, 1);
        pulse_clr(3'b010);
        chk(rx_valid === 1'b0, "R12 rx valid cleared", rx_valid, 0);
    endtask

    task automatic t_irq();
        pulse_clr(3'b100);
        wr_ctrl(10'h200);
        pulse_start(1);
        wait_idle();
        @(negedge clk);
        chk(irq === 1'b0, "R13 irq masked", irq, 0);
        wr_ctrl(10'h240);
        chk(irq === 1'b1, "R13 irq after enable", irq, 1);
        pulse_clr(3'b100);
        chk(irq === 1'b0, "R12 flag cleared", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_paths();
        t_stall();
        t_start_rules();
        t_clear();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule